// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

This block is a watchdog whose timeout is split into four stages that run one after another. Each stage counts its own programmed number of watchdog ticks. A tick is one reference clock cycle multiplied by a 16-bit prescale value. When a stage runs out, the block carries out the action programmed for that stage and moves on to the next stage. The action can be nothing, an interrupt, a CPU reset pulse or a system reset pulse. After the last stage the sequence goes back to the first stage. Software keeps the system alive by feeding the block, which sends it back to the first stage with a cleared count.

All configuration goes through a small write port. A fixed 32-bit key written to the key location unlocks the port, and any other value written there locks it again. While the port is locked, writes to the control word, the timing word, the stage timeouts and the feed location are all dropped. The interrupt can be raised as a held level, as a one-cycle edge, or as both. Each reset output is a pulse whose width is picked by a 3-bit code.

Top module: `wdog_stages`

## Requirements
- R1: After reset all four outputs are low, the write port is locked, and the block is disabled.
- R2: Writing the key 0x5A17C0DE to select 0 unlocks the port, and writing any other value to select 0 locks it. While locked, writes to selects 1 to 7 have no effect, and that includes feeds.
- R3: Once the enable bit (bit 0 of the control word, select 1) goes from 0 to 1, the first stage expires exactly H×P reference cycles later. H is the stage timeout and P is the prescale value in bits [15:0] of the timing word (select 2).
- R4: Stage i has its timeout at select 4+i and its action in control bits [5+2i:4+2i], where 0 is off, 1 is interrupt, 2 is CPU reset and 3 is system reset. A stage whose action is off still counts to its timeout and then hands over, so a later stage fires after the sum of the timeouts.
- R5: Any accepted write to select 3 (feed) returns the block to stage 0 with a cleared count, and it also clears the level interrupt.
- R6: When an interrupt stage expires, irq_level is set and stays high until a restart, but only if control bit 2 is set. irq_edge pulses high for one cycle, but only if control bit 3 is set.
- R7: A stage with the CPU reset action drives cpu_rst only when control bit 1 is set. The pulse width comes from the code in timing bits [18:16].
- R8: A reset code c from 0 to 7 gives a pulse of 8, 16, 24, 32, 40, 64, 128 or 256 reference cycles. The system reset code is in timing bits [21:19].
- R9: After stage 3 expires the block returns to stage 0 and starts its count again.
- R10: A prescale value of 0 or a stage timeout of 0 behaves as 1.
- R11: Reset loads a prescale of 1 and a code of 1 into both reset lengths, so an untouched reset length is 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write select: 0 key, 1 control, 2 timing, 3 feed, 4..7 stage timeouts |
| wr_data | input | 32 | Write data |
| irq_level | output | 1 | Held interrupt |
| irq_edge | output | 1 | One-cycle interrupt pulse |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
If the stage index or the prescale counter held a wrong value, the first interrupt or reset would come out at the wrong cycle. The bench checks every cycle of the expected H×P window, so an error of even one cycle shows up at the first expiry. An error in the lock state or in restart handling shows as an output that rises on the old schedule after a feed, or that appears while the port was meant to be locked. A width code that is decoded wrongly shows as a reset pulse that ends at the wrong cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NSTG = 4;

  typedef enum logic [2:0] {
    SEL_KEY   = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_TIME  = 3'd2,
    SEL_FEED  = 3'd3,
    SEL_HOLD0 = 3'd4,
    SEL_HOLD1 = 3'd5,
    SEL_HOLD2 = 3'd6,
    SEL_HOLD3 = 3'd7
  } wsel_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } act_e;

  // pulse width in reference cycles (8 cycles per 100 ns unit)
  function automatic logic [8:0] len_cycles(input logic [2:0] code);
    case (code)
      3'd0:    len_cycles = 9'd8;
      3'd1:    len_cycles = 9'd16;
      3'd2:    len_cycles = 9'd24;
      3'd3:    len_cycles = 9'd32;
      3'd4:    len_cycles = 9'd40;
      3'd5:    len_cycles = 9'd64;
      3'd6:    len_cycles = 9'd128;
      default: len_cycles = 9'd256;
    endcase
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16,
  parameter logic [31:0] KEY = 32'h5A17_C0DE,
  parameter logic [NSTG*CNT_W-1:0] HOLD_INIT = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [2:0] wr_sel,
  input  logic [31:0] wr_data,
  output logic enable,
  output logic cpu_en,
  output logic lvl_en,
  output logic edge_en,
  output logic [NSTG-1:0][1:0] act,
  output logic [PSC_W-1:0] psc,
  output logic [2:0] cpu_code,
  output logic [2:0] sys_code,
  output logic [NSTG-1:0][CNT_W-1:0] hold,
  output logic restart
);
  localparam int CPU_LSB = PSC_W;
  localparam int SYS_LSB = PSC_W + 3;
  localparam int ACT_LSB = 4;

  logic unlocked;
  logic wr_ok;

  assign wr_ok   = wr_en && unlocked && (wr_sel != SEL_KEY);
  assign restart = wr_ok && ((wr_sel == SEL_FEED) ||
                   ((wr_sel == SEL_CTRL) && wr_data[0] && !enable));

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      enable   <= 1'b0;
      cpu_en   <= 1'b0;
      lvl_en   <= 1'b0;
      edge_en  <= 1'b0;
      act      <= '0;
      psc      <= PSC_W'(1);
      cpu_code <= 3'd1;
      sys_code <= 3'd1;
    end else if (wr_en) begin
      if (wr_sel == SEL_KEY) begin
        unlocked <= (wr_data == KEY);
      end else if (unlocked) begin
        if (wr_sel == SEL_CTRL) begin
          enable  <= wr_data[0];
          cpu_en  <= wr_data[1];
          lvl_en  <= wr_data[2];
          edge_en <= wr_data[3];
          for (int i = 0; i < NSTG; i++)
            act[i] <= wr_data[ACT_LSB+2*i +: 2];
        end else if (wr_sel == SEL_TIME) begin
          psc      <= wr_data[PSC_W-1:0];
          cpu_code <= wr_data[CPU_LSB +: 3];
          sys_code <= wr_data[SYS_LSB +: 3];
        end
      end
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_hold
    localparam logic [2:0] MY_SEL = 3'(4 + g);
    logic [CNT_W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst)
        hold_q <= HOLD_INIT[g*CNT_W +: CNT_W];
      else if (wr_ok && wr_sel == MY_SEL)
        hold_q <= wr_data[CNT_W-1:0];
    end
    assign hold[g] = hold_q;
  end

  // locked writes leave the configuration untouched
  p_locked_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && wr_sel != SEL_KEY) |=>
      ($stable(enable) && $stable(act) && $stable(psc) && $stable(hold)));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic restart,
  input  logic [PSC_W-1:0] psc,
  input  logic [NSTG-1:0][CNT_W-1:0] hold,
  input  logic [NSTG-1:0][1:0] act,
  output logic fire_irq,
  output logic fire_cpu,
  output logic fire_sys
);
  localparam int STG_W = $clog2(NSTG);

  logic [PSC_W-1:0] psc_cnt;
  logic [CNT_W-1:0] stage_cnt;
  logic [STG_W-1:0] stage;
  logic [PSC_W-1:0] psc_eff;
  logic [CNT_W-1:0] hold_eff;
  logic tick, expire;
  act_e cur_act;

  assign psc_eff  = (psc == '0) ? PSC_W'(1) : psc;
  assign hold_eff = (hold[stage] == '0) ? CNT_W'(1) : hold[stage];
  assign tick     = enable && (psc_cnt >= psc_eff - PSC_W'(1));
  assign expire   = tick && (stage_cnt >= hold_eff - CNT_W'(1));
  assign cur_act  = act_e'(act[stage]);

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) begin
      psc_cnt   <= '0;
      stage_cnt <= '0;
      stage     <= '0;
    end else begin
      psc_cnt <= tick ? '0 : psc_cnt + PSC_W'(1);
      if (expire) begin
        stage_cnt <= '0;
        stage     <= stage + STG_W'(1);
      end else if (tick) begin
        stage_cnt <= stage_cnt + CNT_W'(1);
      end
    end
  end

  assign fire_irq = expire && !restart && (cur_act == ACT_IRQ);
  assign fire_cpu = expire && !restart && (cur_act == ACT_CPU);
  assign fire_sys = expire && !restart && (cur_act == ACT_SYS);

  // expiry steps to the next stage, wrapping after the last
  p_stage_step_r4: assert property (@(posedge clk) disable iff (rst)
    (expire && !restart) |=> (stage == $past(stage) + STG_W'(1)));

  // a disabled block holds its sequence at the start
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (stage == '0 && stage_cnt == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic [2:0] code,
  output logic out
);
  logic [8:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (trig) begin
      cnt <= len_cycles(code);
      out <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 9'd1;
      out <= (cnt > 9'd1);
    end
  end
endmodule

// File: rtl/wdog_stages.sv
module wdog_stages
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16,
  parameter logic [31:0] KEY = 32'h5A17_C0DE,
  parameter logic [NSTG*CNT_W-1:0] HOLD_INIT =
    {CNT_W'(1048575), CNT_W'(1048575), CNT_W'(134217727), CNT_W'(26000000)}
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [2:0] wr_sel,
  input  logic [31:0] wr_data,
  output logic irq_level,
  output logic irq_edge,
  output logic cpu_rst,
  output logic sys_rst
);
  logic enable, cpu_en, lvl_en, edge_en, restart;
  logic [NSTG-1:0][1:0] act;
  logic [PSC_W-1:0] psc;
  logic [2:0] cpu_code, sys_code;
  logic [NSTG-1:0][CNT_W-1:0] hold;
  logic fire_irq, fire_cpu, fire_sys;

  wdog_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .KEY(KEY), .HOLD_INIT(HOLD_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .enable(enable), .cpu_en(cpu_en), .lvl_en(lvl_en), .edge_en(edge_en),
    .act(act), .psc(psc), .cpu_code(cpu_code), .sys_code(sys_code),
    .hold(hold), .restart(restart)
  );

  wdog_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk(clk), .rst(rst), .enable(enable), .restart(restart), .psc(psc),
    .hold(hold), .act(act), .fire_irq(fire_irq), .fire_cpu(fire_cpu),
    .fire_sys(fire_sys)
  );

  wdog_pulse u_cpu_pulse (
    .clk(clk), .rst(rst), .trig(fire_cpu && cpu_en), .code(cpu_code), .out(cpu_rst)
  );

  wdog_pulse u_sys_pulse (
    .clk(clk), .rst(rst), .trig(fire_sys), .code(sys_code), .out(sys_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= 1'b0;
      irq_edge  <= 1'b0;
    end else begin
      irq_edge <= fire_irq && edge_en;
      if (restart)
        irq_level <= 1'b0;
      else if (fire_irq && lvl_en)
        irq_level <= 1'b1;
    end
  end

  // CPU reset only starts while its enable is set
  p_cpu_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rst) |-> $past(cpu_en));

  // an accepted restart drops the held interrupt
  p_restart_clears_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> !irq_level);

  // the held interrupt only rises when its enable is set
  p_level_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_level) |-> $past(lvl_en));
endmodule

// File: tb/wdog_stages_tb.sv
module wdog_stages_tb;
  localparam logic [31:0] KEY = 32'h5A17_C0DE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic irq_level, irq_edge, cpu_rst, sys_rst;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_stages u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_level(irq_level), .irq_edge(irq_edge), .cpu_rst(cpu_rst), .sys_rst(sys_rst)
  );

  function automatic int pulse_cycles(input int code);
    if (code < 5) return 8 * (code + 1);
    return 8 * (1 << (code - 2));
  endfunction

  function automatic logic [31:0] ctrl_word(input bit en, input bit cen, input bit lvl,
                                            input bit edg, input int a0, input int a1,
                                            input int a2, input int a3);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = cen; w[2] = lvl; w[3] = edg;
    w[5:4] = 2'(a0); w[7:6] = 2'(a1); w[9:8] = 2'(a2); w[11:10] = 2'(a3);
    return w;
  endfunction

  function automatic logic [31:0] time_word(input int p, input int cc, input int sc);
    return {10'd0, 3'(sc), 3'(cc), 16'(p)};
  endfunction

  function automatic bit sig_of(input int s);
    case (s)
      0: return irq_level;
      1: return irq_edge;
      2: return cpu_rst;
      default: return sys_rst;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a negedge; the write is captured at the following posedge
  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_holds(input int h0, input int h1, input int h2, input int h3);
    wr(3'd4, h0); wr(3'd5, h1); wr(3'd6, h2); wr(3'd7, h3);
  endtask

  // sig expected high for cycles k in [rise, rise+len) after the last write edge
  task automatic watch(input int s, input int rise, input int len, input int horizon,
                       input string tag);
    bit ok = 1'b1;
    int fk = 0, fg = 0, fe = 0;
    for (int k = 1; k <= horizon; k++) begin
      @(negedge clk);
      if (ok && (int'(sig_of(s)) != int'(k >= rise && k < rise + len))) begin
        ok = 1'b0; fk = k; fg = sig_of(s); fe = (k >= rise && k < rise + len);
      end
    end
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, fk, fg, fe);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 irq_level", irq_level, 0);
    chk("R1 irq_edge", irq_edge, 0);
    chk("R1 cpu_rst", cpu_rst, 0);
    chk("R1 sys_rst", sys_rst, 0);

    // R2 locked after reset: enable attempt ignored
    set_holds(1, 1, 1, 1);
    wr(3'd2, time_word(1, 1, 1));
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    watch(0, 1000, 1, 20, "R2 locked after reset");

    // R2 unlock, configure, relock, enable dropped; unlock again and enable works
    wr(3'd0, KEY);
    set_holds(2, 100, 100, 100);
    wr(3'd1, ctrl_word(0, 0, 1, 0, 1, 0, 0, 0));
    wr(3'd0, 32'h1234_5678);
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    watch(0, 1000, 1, 20, "R2 relocked enable ignored");
    wr(3'd0, KEY);
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    watch(0, 2, 1000, 6, "R2 unlocked enable");

    // R2 locked feed is ignored
    do_reset();
    wr(3'd0, KEY);
    wr(3'd4, 6);
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    repeat (2) @(negedge clk);
    wr(3'd0, 32'hDEAD_0000);
    wr(3'd3, 0);
    watch(0, 2, 1000, 6, "R2 locked feed ignored");

    // R3 random prescale and timeout
    for (int it = 0; it < 6; it++) begin
      int p, h;
      p = 1 + int'($urandom % 4);
      h = 1 + int'($urandom % 6);
      do_reset();
      wr(3'd0, KEY);
      wr(3'd4, h);
      wr(3'd2, time_word(p, 1, 1));
      wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
      watch(0, h * p, 1000, h * p + 4, $sformatf("R3 h=%0d p=%0d", h, p));
    end

    // R4 an off stage still counts, next stage fires after sum
    do_reset();
    wr(3'd0, KEY);
    set_holds(3, 4, 100, 100);
    wr(3'd2, time_word(2, 1, 1));
    wr(3'd1, ctrl_word(1, 0, 1, 0, 0, 1, 0, 0));
    watch(0, 14, 1000, 18, "R4 chained stages");

    // R5 feed restarts timing and clears level
    do_reset();
    wr(3'd0, KEY);
    wr(3'd4, 10);
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    repeat (4) @(negedge clk);
    wr(3'd3, 32'hFFFF_FFFF);
    watch(0, 10, 1000, 16, "R5 feed delays expiry");
    wr(3'd3, 0);
    chk("R5 feed clears level", irq_level, 0);

    // R6 edge only: one-cycle pulse, level untouched
    do_reset();
    wr(3'd0, KEY);
    wr(3'd4, 4);
    wr(3'd2, time_word(3, 1, 1));
    wr(3'd1, ctrl_word(1, 0, 0, 1, 1, 0, 0, 0));
    watch(1, 12, 1, 20, "R6 edge pulse");
    wr(3'd3, 0);
    watch(0, 1000, 1, 20, "R6 level disabled");
    // R6 level holds well past expiry
    wr(3'd1, ctrl_word(0, 0, 1, 0, 1, 0, 0, 0));
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    watch(0, 12, 1000, 60, "R6 level held");

    // R7 CPU reset gated by its enable
    do_reset();
    wr(3'd0, KEY);
    wr(3'd4, 5);
    wr(3'd2, time_word(1, 2, 1));
    wr(3'd1, ctrl_word(1, 0, 0, 0, 2, 0, 0, 0));
    watch(2, 1000, 1, 60, "R7 cpu reset suppressed");
    wr(3'd1, ctrl_word(0, 1, 0, 0, 2, 0, 0, 0));
    wr(3'd1, ctrl_word(1, 1, 0, 0, 2, 0, 0, 0));
    watch(2, 5, pulse_cycles(2), 5 + pulse_cycles(2) + 4, "R7 cpu reset width");

    // R8 every system reset code
    for (int c = 0; c < 8; c++) begin
      do_reset();
      wr(3'd0, KEY);
      wr(3'd4, 3);
      wr(3'd2, time_word(1, 1, c));
      wr(3'd1, ctrl_word(1, 0, 0, 0, 3, 0, 0, 0));
      watch(3, 3, pulse_cycles(c), 3 + pulse_cycles(c) + 4,
            $sformatf("R8 sys code %0d", c));
    end

    // R9 wrap after the last stage
    do_reset();
    wr(3'd0, KEY);
    set_holds(2, 2, 2, 2);
    wr(3'd1, ctrl_word(1, 0, 0, 1, 1, 0, 0, 0));
    begin
      bit ok = 1'b1;
      int fk = 0, fg = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (ok && int'(irq_edge) != int'(k % 8 == 2)) begin
          ok = 1'b0; fk = k; fg = irq_edge;
        end
      end
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL R9 wrap at cycle %0d: got %0d expected %0d", fk, fg, 1 - fg);
      end
    end

    // R10 zero prescale and zero timeout act as one
    do_reset();
    wr(3'd0, KEY);
    wr(3'd4, 0);
    wr(3'd2, time_word(0, 1, 1));
    wr(3'd1, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
    watch(0, 1, 1000, 5, "R10 zero values");

    // R11 default width code gives 16 cycles, default prescale 1
    do_reset();
    wr(3'd0, KEY);
    wr(3'd4, 5);
    wr(3'd1, ctrl_word(1, 0, 0, 0, 3, 0, 0, 0));
    watch(3, 5, 16, 26, "R11 default sys width");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule